// File: doc/BRIEF.md
# Key-Protected Independent Watchdog Timer

This block is a watchdog timer that software controls through a small synchronous register port. A slow tick enable drives all counting. A programmable prescaler divides that tick, and each divided tick steps a 12-bit down-counter. When the counter runs out, the block raises a one-cycle reset request and starts a new period on its own. Software keeps the system alive by refreshing the counter before it expires.

All control goes through magic values written to a key register. One key starts the timer. One key refreshes the counter. One key opens the prescaler and reload registers for writing, and every other key value closes them again. A new prescaler or reload value does not reach the counting logic at once. It takes effect after a fixed number of slow ticks, and a per-register busy flag in the status register shows when the transfer is still pending. Once started, the timer can only be halted by the system reset.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the prescaler register reads 0, the reload register reads 0xFFF, the status register reads 0, reset_req is low, the counter is stopped and the configuration registers are locked.
- R2: The register map is as follows. Address 0 is the key register and always reads 0. Address 1 is the prescaler, held in data bits [2:0]. Address 2 is the reload value, held in bits [11:0]. Address 3 is status: bit 0 is the prescaler busy flag and bit 1 is the reload busy flag. reg_rdata always shows the register selected by reg_addr. A write happens when reg_valid and reg_write are both high on a clock edge.
- R3: Writing key 0x5555 unlocks the prescaler and reload registers. Writing any other key value locks them. A write to either register while it is locked leaves both the register and its busy flag unchanged.
- R4: An accepted write to the prescaler or reload register sets that register's busy flag. The new value is applied to the counting logic, and the flag clears, on the third tick-enabled clock edge after the write. Another write while the flag is busy restarts this countdown.
- R5: Key 0xCCCC starts the timer. It loads the counter from the applied reload value and clears the prescaler divider. Only rst_n can stop the timer after that, and reset_req is never high while the timer is stopped.
- R6: Prescaler code c from 0 to 6 divides the tick by 4·2^c. Code 7 divides by 256.
- R7: With applied reload R and divisor D, reset_req goes high for exactly one cycle (R+1)·D tick-enabled edges after a start or refresh. The counter then reloads, and the next pulse follows (R+1)·D ticks later.
- R8: Key 0xAAAA reloads the counter from the applied reload value and restarts the divider. Before the timer is started it produces no reset request.
- R9: While tick_en is low, neither the divider, the counter nor a busy countdown advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access strobe |
| reg_write | input | 1 | Access is a write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| tick_en | input | 1 | Slow tick enable |
| reset_req | output | 1 | One-cycle reset request on expiry |

## Verification
Read data is combinational, so a register value or flag changed by the write edge can be sampled at the very next falling edge. A busy flag stays set at the first three falling edges after the write edge and must read clear at the fourth. reset_req is a register set on the expiring edge, so the bench counts tick-enabled edges from the start or refresh edge and expects the pulse at the falling edge after edge (R+1)·D, low again one edge later. The timing sweep covers every prescaler code with three reload values, taking the reset request as the pulse of interest, and each measurement begins only after the busy flags have cleared.

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 12,
  parameter int BUSY_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              tick_en,
  output logic              reset_req
);
  localparam int BT_W = $clog2(BUSY_TICKS + 1);
  localparam logic [DATA_W-1:0] KEY_START  = DATA_W'(16'hCCCC);
  localparam logic [DATA_W-1:0] KEY_KICK   = DATA_W'(16'hAAAA);
  localparam logic [DATA_W-1:0] KEY_UNLOCK = DATA_W'(16'h5555);

  logic             unlocked, running;
  logic [2:0]       pre_sh, pre_act;
  logic [CNT_W-1:0] rl_sh, rl_act, cnt;
  logic [7:0]       div;
  logic [BT_W-1:0]  pbusy_cnt, rbusy_cnt;

  wire wr       = reg_valid & reg_write;
  wire key_wr   = wr && reg_addr == 2'd0;
  wire k_start  = key_wr && reg_wdata == KEY_START;
  wire k_kick   = key_wr && reg_wdata == KEY_KICK;
  wire pre_wr   = wr && reg_addr == 2'd1 && unlocked;
  wire rl_wr    = wr && reg_addr == 2'd2 && unlocked;
  wire pre_busy = |pbusy_cnt;
  wire rl_busy  = |rbusy_cnt;

  wire [8:0] div_full = 9'd4 << pre_act;
  wire [7:0] div_max  = (pre_act == 3'd7) ? 8'hFF : div_full[7:0] - 8'd1;
  wire       ptick    = running && tick_en && div == div_max;

  always_comb begin
    case (reg_addr)
      2'd1:    reg_rdata = DATA_W'(pre_sh);
      2'd2:    reg_rdata = DATA_W'(rl_sh);
      2'd3:    reg_rdata = DATA_W'({rl_busy, pre_busy});
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked  <= 1'b0;
      running   <= 1'b0;
      pre_sh    <= '0;
      pre_act   <= '0;
      rl_sh     <= '1;
      rl_act    <= '1;
      cnt       <= '1;
      div       <= '0;
      pbusy_cnt <= '0;
      rbusy_cnt <= '0;
      reset_req <= 1'b0;
    end else begin
      reset_req <= 1'b0;
      if (key_wr) unlocked <= (reg_wdata == KEY_UNLOCK);

      if (pre_wr) begin
        pre_sh    <= reg_wdata[2:0];
        pbusy_cnt <= BT_W'(BUSY_TICKS);
      end else if (tick_en && pre_busy) begin
        pbusy_cnt <= pbusy_cnt - 1'b1;
        if (pbusy_cnt == BT_W'(1)) pre_act <= pre_sh;
      end

      if (rl_wr) begin
        rl_sh     <= reg_wdata[CNT_W-1:0];
        rbusy_cnt <= BT_W'(BUSY_TICKS);
      end else if (tick_en && rl_busy) begin
        rbusy_cnt <= rbusy_cnt - 1'b1;
        if (rbusy_cnt == BT_W'(1)) rl_act <= rl_sh;
      end

      if (k_start) running <= 1'b1;

      if (k_start || k_kick) begin
        cnt <= rl_act;
        div <= '0;
      end else if (running && tick_en) begin
        div <= ptick ? 8'd0 : div + 8'd1;
        if (ptick) begin
          if (cnt == '0) begin
            reset_req <= 1'b1;
            cnt       <= rl_act;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_valid,
  input logic       reg_write,
  input logic [1:0] reg_addr,
  input logic       tick_en,
  input logic       reset_req,
  input logic       running,
  input logic       unlocked,
  input logic [2:0] pre_sh,
  input logic       pre_busy
);
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  assert_req_needs_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> running);

  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);

  assert_locked_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == 2'd1 && !unlocked) |=> $stable(pre_sh));

  assert_busy_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_valid && reg_write && reg_addr == 2'd1 && unlocked) |=> pre_busy);

  assert_busy_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pre_busy) |-> $past(tick_en));
endmodule

bind keyed_watchdog keyed_watchdog_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_addr(reg_addr), .tick_en(tick_en), .reset_req(reset_req),
  .running(running), .unlocked(unlocked), .pre_sh(pre_sh), .pre_busy(pre_busy)
);

// File: tb/keyed_watchdog_tb_top.sv
module keyed_watchdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0, tick_en = 1'b1;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        reset_req;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  keyed_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tick_en(tick_en), .reset_req(reset_req)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; reg_valid = 1'b0; tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 1; i <= 5000; i++) begin
      @(negedge clk);
      if (reset_req) begin n = i; break; end
    end
  endtask

  task automatic config_wd(input int code, input int rl);
    wr(0, 16'h5555); wr(1, 16'(code)); wr(2, 16'(rl)); wr(0, 16'h0000);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, n, d;
    do_reset();
    rd(1, v); check("R1 prescaler", v, 0);
    rd(2, v); check("R1 reload", v, 4095);
    rd(3, v); check("R1 status", v, 0);
    check("R1 reset_req", int'(reset_req), 0);

    wr(1, 16'h0005); rd(1, v); check("R3 locked prescaler", v, 0);
    rd(3, v); check("R3 locked status", v, 0);
    wr(0, 16'h5555); wr(0, 16'h1234); wr(2, 16'h0007);
    rd(2, v); check("R3 relocked reload", v, 4095);
    rd(0, v); check("R2 key reads zero", v, 0);

    wr(0, 16'h5555); wr(1, 16'h0003);
    rd(1, v); check("R2 prescaler readback", v, 3);
    rd(3, v); check("R4 busy at +0", v, 1);
    @(negedge clk); rd(3, v); check("R4 busy at +1", v, 1);
    @(negedge clk); rd(3, v); check("R4 busy at +2", v, 1);
    @(negedge clk); rd(3, v); check("R4 clear at +3", v, 0);
    wr(2, 16'h0ABC); rd(2, v); check("R2 reload readback", v, 16'hABC);
    rd(3, v); check("R4 reload busy bit", v, 2);
    tick_en = 1'b0;
    repeat (10) @(negedge clk);
    rd(3, v); check("R9 busy frozen", v, 2);
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    rd(3, v); check("R9 busy clears after ticks", v, 0);

    for (int code = 0; code < 8; code++) begin
      for (int k = 0; k < 3; k++) begin
        int r;
        r = (k == 0) ? 0 : (k == 1) ? 1 : 5;
        d = (code == 7) ? 256 : (4 << code);
        do_reset();
        config_wd(code, r);
        wr(0, 16'hCCCC);
        measure(n); check("R6 R7 first expiry", n, (r + 1) * d);
        measure(n); check("R7 repeat period", n, (r + 1) * d);
        check("R7 single cycle", (n > 1) ? 1 : 0, 1);
      end
    end

    do_reset();
    config_wd(0, 3);
    wr(0, 16'hAAAA);
    n = 0;
    repeat (60) begin @(negedge clk); if (reset_req) n++; end
    check("R8 kick before start", n, 0);
    wr(0, 16'hCCCC);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      repeat (8) begin @(negedge clk); if (reset_req) n++; end
      wr(0, 16'hAAAA);
    end
    check("R8 refreshed no request", n, 0);
    measure(n); check("R8 expiry after last kick", n, 16);
    wr(0, 16'h0000); wr(0, 16'h1111);
    measure(n); check("R5 cannot stop", (n > 0) ? 1 : 0, 1);

    do_reset();
    config_wd(0, 0);
    wr(0, 16'hCCCC);
    tick_en = 1'b0;
    n = 0;
    repeat (20) begin @(negedge clk); if (reset_req) n++; end
    check("R9 frozen counter", n, 0);
    tick_en = 1'b1;
    measure(n); check("R9 resume count", n, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule